// File: doc/BRIEF.md
# Banked Warp Scratchpad with Conflict Replay

This block is an on-chip scratchpad shared by all lanes of a warp. Its storage is split into independent single-ported banks. A whole warp presents one request at a time. The request carries a valid bit, a word address and write data for every lane, plus one flag that selects read or write for the warp.

The low address bits pick the bank and the next bits pick the row inside that bank. In each service cycle, every bank serves at most one lane. When several lanes target the same bank, the lowest-numbered one is served first and the others are replayed in later cycles.

The request is held, with ready low, until every valid lane has been served. The block then gives a one-cycle done pulse together with the number of service cycles used. Read data for each lane is available on the data outputs at the same time.

Top module: `banked_scratchpad`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `cycles` is 0.
- R2: With the default parameters, the bank is address bits [4:0] and the row is bits [9:5]. Address bits above bit 9 are ignored, so two addresses that differ only there reach the same word. A request whose valid lanes all fall in distinct banks completes in one cycle.
- R3: A bank serves at most one lane per service cycle. Among the pending lanes that map to a bank, the lowest-numbered lane is served first.
- R4: The reported `cycles` value equals the largest number of valid lanes that map to any single bank. A single two-way conflict therefore reports 2, and 32 lanes in one bank report 32.
- R5: `req_ready` falls on the clock edge that accepts a request and stays low until completion. The number of cycles it is low equals the reported `cycles`.
- R6: `done` is high for exactly one cycle. During that cycle, the `rd_data` slice of each valid lane of a read holds the word stored at that lane's address.
- R7: Lanes whose valid bit is 0 neither read nor write. A request with no valid lanes completes with `cycles` equal to 1.
- R8: Writes to one bank are applied in lane order. When several lanes write the same address, the highest-numbered lane's data remains.
- R9: A strided pattern costs no extra cycles while the lanes land in distinct banks. With the default parameters, stride 3 reports 1 and stride 2 reports 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A warp request is presented |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_write | input | 1 | 1 = write the warp's data, 0 = read |
| lane_valid | input | LANES | Per-lane valid bits |
| lane_addr | input | LANES*ADDR_W | Per-lane word addresses; lane n uses slice n |
| lane_wdata | input | LANES*DATA_W | Per-lane write data |
| rd_data | output | LANES*DATA_W | Per-lane read data; valid when done is high |
| done | output | 1 | One-cycle pulse when all lanes have been served |
| cycles | output | CNT_W | Service cycles used by the last request |

## Verification
The bench sends warps whose lanes all hit one bank, warps with a single two-way collision, and strided patterns. A design that mis-counted occupancy, or that served only one lane per cycle, would report the wrong cycle count or hold ready low for the wrong time. Same-address writes from every lane check the lane order: a design that granted the highest lane first would leave lane 0's data behind. Address aliasing in the upper bits and warps with sparse or empty valid masks check that unused bits and idle lanes have no effect on stored words or on the cycle count.

// File: rtl/spad_pkg.sv
package spad_pkg;
  // bank index: low bits of the word address
  function automatic int unsigned bank_of(input logic [31:0] addr, input int unsigned bank_w);
    return int'(addr & ((32'd1 << bank_w) - 32'd1));
  endfunction

  // row within a bank: the bits just above the bank index
  function automatic int unsigned row_of(input logic [31:0] addr, input int unsigned bank_w,
                                         input int unsigned row_w);
    return int'((addr >> bank_w) & ((32'd1 << row_w) - 32'd1));
  endfunction
endpackage

// File: rtl/spad_arbiter.sv
module spad_arbiter #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int BANK_W = 5,
  parameter int LANE_W = 5
) (
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
  output logic [LANES-1:0]             lane_grant,
  output logic [BANKS-1:0]             bank_en,
  output logic [BANKS-1:0][LANE_W-1:0] bank_lane
);
  always_comb begin
    bank_en    = '0;
    bank_lane  = '0;
    lane_grant = '0;
    for (int b = 0; b < BANKS; b++) begin
      // descending scan: the lowest pending lane is the last to be written
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && lane_bank[l] == BANK_W'(b)) begin
          bank_en[b]   = 1'b1;
          bank_lane[b] = LANE_W'(l);
        end
      end
    end
    for (int b = 0; b < BANKS; b++) begin
      if (bank_en[b]) lane_grant[bank_lane[b]] = 1'b1;
    end
  end
endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
  parameter int ROWS   = 32,
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en && we) mem[row] <= wdata;
  end

  assign rdata = mem[row];
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ROWS   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [LANES-1:0]         lane_valid,
  input  logic [LANES*ADDR_W-1:0]  lane_addr,
  input  logic [LANES*DATA_W-1:0]  lane_wdata,
  output logic [LANES*DATA_W-1:0]  rd_data,
  output logic                     done,
  output logic [CNT_W-1:0]         cycles
);
  import spad_pkg::*;

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int LANE_W = $clog2(LANES);

  logic                            busy;
  logic                            write_q;
  logic [LANES-1:0]                pending_q;
  logic [LANES-1:0][ADDR_W-1:0]    addr_q;
  logic [LANES-1:0][DATA_W-1:0]    wdata_q;
  logic [LANES-1:0][DATA_W-1:0]    rd_q;
  logic [CNT_W-1:0]                cyc_q;

  logic [LANES-1:0][BANK_W-1:0]    lane_bank;
  logic [LANES-1:0][ROW_W-1:0]     lane_row;
  logic [LANES-1:0]                lane_grant;
  logic [BANKS-1:0]                bank_en;
  logic [BANKS-1:0][LANE_W-1:0]    bank_lane;
  logic [BANKS-1:0][DATA_W-1:0]    bank_rdata;
  logic                            accept;
  logic                            last_cycle;

  assign req_ready  = !busy;
  assign accept     = req_valid && !busy;
  assign last_cycle = busy && ((pending_q & ~lane_grant) == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bank[l] = BANK_W'(bank_of(32'(addr_q[l]), BANK_W));
    assign lane_row[l]  = ROW_W'(row_of(32'(addr_q[l]), BANK_W, ROW_W));
    assign rd_data[l*DATA_W +: DATA_W] = rd_q[l];
  end

  spad_arbiter #(.LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .LANE_W(LANE_W)) u_arb (
    .pending   (busy ? pending_q : '0),
    .lane_bank (lane_bank),
    .lane_grant(lane_grant),
    .bank_en   (bank_en),
    .bank_lane (bank_lane)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    spad_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk  (clk),
      .en   (bank_en[b]),
      .we   (write_q),
      .row  (lane_row[bank_lane[b]]),
      .wdata(wdata_q[bank_lane[b]]),
      .rdata(bank_rdata[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      write_q   <= 1'b0;
      pending_q <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      cyc_q     <= '0;
      done      <= 1'b0;
      cycles    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        write_q   <= req_write;
        pending_q <= lane_valid;
        cyc_q     <= CNT_W'(1);
        for (int l = 0; l < LANES; l++) begin
          addr_q[l]  <= lane_addr[l*ADDR_W +: ADDR_W];
          wdata_q[l] <= lane_wdata[l*DATA_W +: DATA_W];
        end
      end else if (busy) begin
        pending_q <= pending_q & ~lane_grant;
        if (last_cycle) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          cycles <= cyc_q;
        end else begin
          cyc_q <= cyc_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (busy && !write_q && lane_grant[l]) rd_q[l] <= bank_rdata[lane_bank[l]];
      end
    end
  end
endmodule

// File: rtl/spad_checker.sv
module spad_checker #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic [CNT_W-1:0] cycles,
  input logic [LANES-1:0] pending_q,
  input logic [LANES-1:0] lane_grant,
  input logic [BANKS-1:0] bank_en
);
  // each enabled bank grants exactly one lane, so the counts match
  assert_one_grant_per_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(lane_grant) == $countones(bank_en)));

  assert_grant_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_grant & ~pending_q) == '0);

  assert_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pending_q != '0) |-> lane_grant != '0);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles >= CNT_W'(1) && cycles <= CNT_W'(LANES)));

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind banked_scratchpad spad_checker #(.LANES(LANES), .BANKS(BANKS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .cycles    (cycles),
  .pending_q (pending_q),
  .lane_grant(lane_grant),
  .bank_en   (bank_en)
);

// File: tb/banked_scratchpad_tb.sv
module banked_scratchpad_tb;
  localparam int L = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [L-1:0]  lane_valid = '0;
  logic [L*32-1:0] lane_addr = '0;
  logic [L*32-1:0] lane_wdata = '0;
  logic          req_ready;
  logic [L*32-1:0] rd_data;
  logic          done;
  logic [5:0]    cycles;

  int checks = 0;
  int errors = 0;

  logic [31:0] a [L];
  logic [31:0] d [L];
  logic [31:0] model [1024];

  always #2.5 clk = ~clk;

  banked_scratchpad u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .lane_valid(lane_valid), .lane_addr(lane_addr),
    .lane_wdata(lane_wdata), .rd_data(rd_data), .done(done), .cycles(cycles)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // worst bank occupancy among valid lanes, at least one
  function automatic int occupancy(input logic [L-1:0] v);
    int cnt [32];
    int mx = 1;
    foreach (cnt[i]) cnt[i] = 0;
    for (int l = 0; l < L; l++) if (v[l]) cnt[a[l] % 32]++;
    foreach (cnt[i]) if (cnt[i] > mx) mx = cnt[i];
    return mx;
  endfunction

  task automatic run(input bit wr, input logic [L-1:0] v, input int exp_cyc, input string req);
    int low = 0;
    int guard = 0;
    bit data_ok = 1'b1;
    int bad = 0;
    @(negedge clk);
    req_write  = wr;
    lane_valid = v;
    for (int l = 0; l < L; l++) begin
      lane_addr[l*32 +: 32]  = a[l];
      lane_wdata[l*32 +: 32] = d[l];
    end
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 200) begin
      if (!req_ready) low++;
      guard++;
      @(negedge clk);
    end
    check(guard < 200, req, "done seen before watchdog", guard, 0);
    check(occupancy(v) == exp_cyc, req, "bench occupancy", occupancy(v), exp_cyc);
    check(cycles == 6'(exp_cyc), req, "reported cycles", cycles, exp_cyc);
    check(low == exp_cyc, "R5", "ready-low cycles", low, exp_cyc);
    if (wr) begin
      for (int l = 0; l < L; l++) if (v[l]) model[a[l][9:0]] = d[l];
    end else begin
      for (int l = 0; l < L; l++)
        if (v[l] && rd_data[l*32 +: 32] !== model[a[l][9:0]]) begin
          data_ok = 1'b0;
          bad = l;
        end
      check(data_ok, "R6", "read data lane", rd_data[bad*32 +: 32], model[a[bad][9:0]]);
    end
    @(negedge clk);
    check(!done, "R6", "done width", done, 0);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(cycles == '0, "R1", "cycles after reset", cycles, 0);
  endtask

  task automatic t_linear();  // R2: one lane per bank
    for (int l = 0; l < L; l++) begin a[l] = 32'h40 + l; d[l] = 32'hA000 + l; end
    run(1'b1, '1, 1, "R2");
    run(1'b0, '1, 1, "R2");
  endtask

  task automatic t_one_bank();  // R4: all lanes in bank 3
    for (int l = 0; l < L; l++) begin a[l] = l * 32 + 3; d[l] = 32'hB000 + l; end
    run(1'b1, '1, 32, "R4");
    run(1'b0, '1, 32, "R4");
  endtask

  task automatic t_two_way();  // R4: lanes 0 and 1 collide
    for (int l = 0; l < L; l++) begin a[l] = 32'h80 + l; d[l] = 32'hC000 + l; end
    a[1] = 32'h80 + 32'h20;
    run(1'b1, '1, 2, "R4");
    run(1'b0, '1, 2, "R4");
  endtask

  task automatic t_strides();  // R9
    for (int l = 0; l < L; l++) begin a[l] = 32'h100 + 3 * l; d[l] = 32'hD000 + l; end
    run(1'b1, '1, 1, "R9");
    for (int l = 0; l < L; l++) a[l] = 32'h100 + 2 * l;
    run(1'b0, '1, 2, "R9");
  endtask

  task automatic t_invalid();  // R7
    run(1'b0, '0, 1, "R7");
    for (int l = 0; l < L; l++) begin a[l] = 32'h40 + l; d[l] = 32'hEEEE_0000 + l; end
    run(1'b1, 32'h0000_FFFF, 1, "R7");   // upper lanes must not overwrite
    run(1'b0, '1, 1, "R7");
    check(rd_data[31*32 +: 32] == 32'hA000 + 31, "R7", "invalid lane word kept",
          rd_data[31*32 +: 32], 32'hA000 + 31);
  endtask

  task automatic t_same_addr();  // R8 and R3 order
    for (int l = 0; l < L; l++) begin a[l] = 32'h5; d[l] = 32'hF000 + l; end
    run(1'b1, '1, 32, "R8");
    a[0] = 32'h5;
    run(1'b0, 32'h1, 1, "R8");
    check(rd_data[31:0] == 32'hF000 + 31, "R8", "highest lane wins",
          rd_data[31:0], 32'hF000 + 31);
  endtask

  task automatic t_alias();  // R2: upper bits ignored
    for (int l = 0; l < L; l++) begin a[l] = 32'h7 + 32'h20 * (l % 32); d[l] = l; end
    a[0] = 32'h0001_0407; d[0] = 32'h1234_5678;
    run(1'b1, 32'h1, 1, "R2");
    a[0] = 32'h7;
    run(1'b0, 32'h1, 1, "R2");
    check(rd_data[31:0] == 32'h1234_5678, "R2", "alias read",
          rd_data[31:0], 32'h1234_5678);
  endtask

  initial begin
    bit wd_hit = 1'b0;
    foreach (model[i]) model[i] = 'x;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_one_bank();
        t_two_way();
        t_strides();
        t_invalid();
        t_same_addr();
        t_alias();
      end
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) check(1'b0, "R5", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule